// File: doc/BRIEF.md
# Saturating Fixed-Point Biquad Section

This block is one second-order recursive filter section for audio samples held as 16-bit signed fractions (1.15: the code 0x8000 stands for -1.0 and 0x7FFF for 32767/32768). Each sample arrives with a one-cycle valid strobe. The block can first scale the sample down by a power of two to make room for filter gain. It then forms five products of the current sample, two earlier inputs and two earlier outputs with five programmable coefficients, and adds them in a 32-bit two's-complement accumulator. That accumulator is allowed to wrap while the sum is being formed.

Only the finished sum is rounded and clamped back to 16 bits. When the clamp changes the value, a one-cycle clip flag accompanies that output sample. Coefficients are signed 16-bit values in 2.14 format, so the range reaches -2.0 up to just under +2.0. They are loaded one at a time through a small write port. Each rounded and clamped output is also the value fed back into the output history.

Top module: `biquad_sat_df1`

## Requirements
- R1: After synchronous reset, out_valid and clip are low, out_sample is zero, all five coefficients are zero and all four history samples (two inputs, two outputs) are zero.
- R2: Each output is y = b0*x[n] + b1*x[n-1] + b2*x[n-2] - a1*y[n-1] - a2*y[n-2]. Samples are 1.15 and coefficients 2.14. a1 and a2 are stored as written and subtracted by the block.
- R3: A write with cfg_we high stores cfg_data into b0, b1, b2, a1 or a2 for cfg_addr 0, 1, 2, 3 or 4 respectively. Writes to addresses 5, 6 and 7 change nothing.
- R4: A coefficient write applies to every sample accepted after the write cycle. A sample accepted in the same cycle as a write still uses the previous value.
- R5: A sample accepted in cycle c produces a one-cycle out_valid pulse in cycle c+2. Successive in_valid pulses must have at least one idle cycle between them.
- R6: The five products are summed in a 32-bit accumulator that may wrap partway through. The result used is the exact sum modulo 2^32.
- R7: The accumulator is rounded to nearest by adding 2^13, then shifted right arithmetically by 14 bits. Exact halves round toward plus infinity. Rounding happens before the range check.
- R8: A rounded result above 32767 gives 0x7FFF, and one below -32768 gives 0x8000. clip is high together with out_valid exactly for such clamped samples.
- R9: The input sample is arithmetically shifted right by atten (0 to 3), which is captured with in_valid. The scaled value is used both in the product and in the input history.
- R10: The histories advance only on accepted samples. The output history holds the clamped output value, not the raw accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Input sample, 1.15 two's complement |
| atten | input | 2 | Input right-shift amount (6 dB per step) |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 3 | Coefficient select: 0 b0, 1 b1, 2 b2, 3 a1, 4 a2 |
| cfg_data | input | 16 | Coefficient value, 2.14 two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Filtered sample, 1.15 two's complement |
| clip | output | 1 | Output sample was clamped |

## Verification
The hardest case to reach is a sum that wraps inside the accumulator and still ends in range. This needs the feedforward products to pass 2^31 while the feedback products pull the total back. The stimulus sets every coefficient near +2.0 and drives two full-scale samples, which saturate the output history at 32767. A third, small sample then makes the positive partial sum wrap, and the correct, unclamped output is 100. Rounding ties on both sides of zero, coefficient writes in the same cycle as a sample, and writes to unused addresses are each driven as their own short scenario.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

    localparam int DATA_W    = 16;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int ACC_W     = DATA_W + COEF_W;
    localparam int RND_W     = ACC_W + 1;
    localparam int NUM_TAPS  = 5;
    localparam int NUM_FF    = 3;
    localparam int ADDR_W    = 3;
    localparam int ATT_W     = 2;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [RND_W-1:0]  rnd_t;

    typedef enum logic [ADDR_W-1:0] {
        TAP_B0 = ADDR_W'(0),
        TAP_B1 = ADDR_W'(1),
        TAP_B2 = ADDR_W'(2),
        TAP_A1 = ADDR_W'(3),
        TAP_A2 = ADDR_W'(4)
    } tap_e;

    typedef struct packed {
        coef_t b0;
        coef_t b1;
        coef_t b2;
        coef_t a1;
        coef_t a2;
    } coef_set_t;

    typedef struct packed {
        sample_t x1;
        sample_t x2;
        sample_t y1;
        sample_t y2;
    } hist_t;

    typedef struct packed {
        sample_t y;
        logic    clip;
    } qres_t;

    localparam sample_t SAMPLE_MAX = sample_t'({1'b0, {(DATA_W-1){1'b1}}});
    localparam sample_t SAMPLE_MIN = sample_t'({1'b1, {(DATA_W-1){1'b0}}});

    // Round half up, drop fraction bits, clamp to the sample range.
    function automatic qres_t round_sat(acc_t a);
        rnd_t  r;
        rnd_t  hi;
        rnd_t  lo;
        qres_t q;
        r  = rnd_t'(a) + (rnd_t'(1) <<< (COEF_FRAC - 1));
        r  = r >>> COEF_FRAC;
        hi = rnd_t'(SAMPLE_MAX);
        lo = rnd_t'(SAMPLE_MIN);
        if (r > hi) begin
            q.y    = SAMPLE_MAX;
            q.clip = 1'b1;
        end else if (r < lo) begin
            q.y    = SAMPLE_MIN;
            q.clip = 1'b1;
        end else begin
            q.y    = r[DATA_W-1:0];
            q.clip = 1'b0;
        end
        return q;
    endfunction

endpackage

// File: rtl/biquad_coef_bank.sv
module biquad_coef_bank
    import biquad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  coef_t             cfg_data,
    output coef_set_t         coefs
);

    coef_t bank [NUM_TAPS];
    tap_e  sel;

    assign sel = tap_e'(cfg_addr);

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (cfg_we && (sel == tap_e'(g))) begin
                bank[g] <= cfg_data;
            end
        end
    end

    assign coefs.b0 = bank[TAP_B0];
    assign coefs.b1 = bank[TAP_B1];
    assign coefs.b2 = bank[TAP_B2];
    assign coefs.a1 = bank[TAP_A1];
    assign coefs.a2 = bank[TAP_A2];

    // R3
    coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(coefs));

    // R3
    coef_badaddr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_addr >= ADDR_W'(NUM_TAPS))) |=> $stable(coefs));

endmodule

// File: rtl/biquad_mac.sv
module biquad_mac
    import biquad_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  sample_t   x_cur,
    input  hist_t     hist,
    input  coef_set_t coefs,
    output acc_t      acc,
    output logic      acc_valid
);

    sample_t opnd [NUM_TAPS];
    coef_t   cval [NUM_TAPS];
    acc_t    prod_q [NUM_TAPS];

    assign opnd[0] = x_cur;
    assign opnd[1] = hist.x1;
    assign opnd[2] = hist.x2;
    assign opnd[3] = hist.y1;
    assign opnd[4] = hist.y2;

    assign cval[0] = coefs.b0;
    assign cval[1] = coefs.b1;
    assign cval[2] = coefs.b2;
    assign cval[3] = coefs.a1;
    assign cval[4] = coefs.a2;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_mul
        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q[g] <= '0;
            end else if (in_valid) begin
                prod_q[g] <= acc_t'(opnd[g]) * acc_t'(cval[g]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_valid <= 1'b0;
        else     acc_valid <= in_valid;
    end

    // Wrapping sum: feedforward terms added, feedback terms subtracted.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (i < NUM_FF) acc = acc + prod_q[i];
            else            acc = acc - prod_q[i];
        end
    end

    // R5
    acc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> !acc_valid);

endmodule

// File: rtl/biquad_quant.sv
module biquad_quant
    import biquad_pkg::*;
(
    input  acc_t    acc,
    output sample_t y,
    output logic    clip
);

    qres_t q;

    always_comb begin
        q    = round_sat(acc);
        y    = q.y;
        clip = q.clip;
    end

    // R8
    always_comb begin
        quant_code_chk: assert (!clip || (y == SAMPLE_MAX) || (y == SAMPLE_MIN));
    end

endmodule

// File: rtl/biquad_sat_df1.sv
module biquad_sat_df1
    import biquad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic [ATT_W-1:0]  atten,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [COEF_W-1:0] cfg_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample,
    output logic              clip
);

    coef_set_t coefs;
    hist_t     hist;
    sample_t   in_s;
    sample_t   x_att;
    acc_t      acc;
    logic      acc_valid;
    sample_t   yq;
    logic      yq_clip;
    sample_t   out_q;

    assign in_s  = sample_t'(in_sample);
    assign x_att = in_s >>> atten;

    biquad_coef_bank u_coef (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (coef_t'(cfg_data)),
        .coefs    (coefs)
    );

    biquad_mac u_mac (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .x_cur     (x_att),
        .hist      (hist),
        .coefs     (coefs),
        .acc       (acc),
        .acc_valid (acc_valid)
    );

    biquad_quant u_quant (
        .acc  (acc),
        .y    (yq),
        .clip (yq_clip)
    );

    // Input history moves with each accepted sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist.x1 <= '0;
            hist.x2 <= '0;
        end else if (in_valid) begin
            hist.x1 <= x_att;
            hist.x2 <= hist.x1;
        end
    end

    // Output history and output registers move with each finished sum.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist.y1   <= '0;
            hist.y2   <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
            clip      <= 1'b0;
        end else begin
            out_valid <= acc_valid;
            clip      <= acc_valid & yq_clip;
            if (acc_valid) begin
                hist.y1 <= yq;
                hist.y2 <= hist.y1;
                out_q   <= yq;
            end
        end
    end

    assign out_sample = out_q;

    // R5
    in_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !in_valid);

    // R5
    out_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R8
    clip_code_chk: assert property (@(posedge clk) disable iff (rst)
        clip |-> (out_valid && ((out_q == SAMPLE_MAX) || (out_q == SAMPLE_MIN))));

    // R10
    xhist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (hist.x2 == $past(hist.x1)));

    // R10
    xhist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(hist.x1) && $stable(hist.x2)));

    // R10
    yhist_fb_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((hist.y1 == out_q) && (hist.y2 == $past(hist.y1))));

endmodule

// File: tb/biquad_sat_df1_tb.sv
module biquad_sat_df1_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [1:0]  atten = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        out_valid;
    logic [15:0] out_sample;
    logic        clip;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    longint mc [5];
    longint mx1, mx2, my1, my2;

    always #(CLK_PERIOD/2) clk = ~clk;

    biquad_sat_df1 u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .atten      (atten),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .clip       (clip)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Reference arithmetic taken from the requirements.
    task automatic model_step(input int x, input int att, output longint y, output longint c);
        longint xa, s, r;
        logic signed [31:0] w;
        xa = longint'(x) >>> att;
        s  = mc[0]*xa + mc[1]*mx1 + mc[2]*mx2 - mc[3]*my1 - mc[4]*my2;
        w  = s[31:0];
        r  = (longint'(w) + 8192) >>> 14;
        c  = 0;
        if (r > 32767)       begin r = 32767;  c = 1; end
        else if (r < -32768) begin r = -32768; c = 1; end
        y   = r;
        mx2 = mx1; mx1 = xa;
        my2 = my1; my1 = r;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        foreach (mc[i]) mc[i] = 0;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    endtask

    task automatic wcoef(input int addr, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_data = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 5) mc[addr] = longint'($signed(16'(val)));
    endtask

    task automatic send(input int x, input int att, input string tag,
                        output int y_o, output bit c_o);
        longint ey, ec;
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(x); atten = 2'(att);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 no output at c+1", longint'(out_valid), 0);
        @(negedge clk);
        chk("R5 output at c+2", longint'(out_valid), 1);
        y_o = int'($signed(out_sample));
        c_o = clip;
        model_step(x, att, ey, ec);
        chk(tag, longint'(y_o), ey);
        chk({tag, " clip"}, longint'(c_o), ec);
        @(negedge clk);
        chk("R5 single pulse", longint'(out_valid), 0);
    endtask

    task automatic t_reset();
        int y; bit c;
        do_reset();
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 out_sample", longint'(out_sample), 0);
        chk("R1 clip", longint'(clip), 0);
        send(20000, 0, "R1 zero coefficients", y, c);
        chk("R1 zero coefficients explicit", longint'(y), 0);
        do_reset();
        wcoef(1, 16'h4000);
        send(12345, 0, "R1 cleared x history", y, c);
        chk("R1 cleared x history explicit", longint'(y), 0);
        send(0, 0, "R2 b1 tap", y, c);
        chk("R2 b1 tap explicit", longint'(y), 12345);
    endtask

    task automatic t_map();
        int y; bit c;
        do_reset();
        wcoef(2, 16'h4000);
        send(1000, 0, "R3 b2 addr", y, c);
        send(0, 0, "R3 b2 addr", y, c);
        send(0, 0, "R3 b2 addr", y, c);
        chk("R3 b2 at addr 2", longint'(y), 1000);
        wcoef(5, 16'h7FFF);
        wcoef(6, 16'h7FFF);
        wcoef(7, 16'h7FFF);
        send(3000, 0, "R3 unused addr ignored", y, c);
        chk("R3 unused addr ignored explicit", longint'(y), 0);
    endtask

    task automatic t_feedback();
        int y; bit c;
        do_reset();
        wcoef(0, 16'h4000);
        wcoef(3, 16'hE000);
        wcoef(4, 16'h1000);
        send(16384, 0, "R2 feedback", y, c);
        send(0, 0, "R2 feedback", y, c);
        chk("R2 a1 subtracted", longint'(y), 8192);
        send(0, 0, "R2 feedback", y, c);
        chk("R2 a2 subtracted", longint'(y), 0);
        for (int i = 0; i < 6; i++) begin
            send((i % 2 == 0) ? -7000 : 9000, 0, "R2 mixed input", y, c);
        end
    endtask

    task automatic t_coef_timing();
        longint ey, ec;
        int y; bit c;
        do_reset();
        wcoef(0, 16'h4000);
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'd1000; atten = 2'd0;
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_data = 16'h2000;
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        model_step(1000, 0, ey, ec);
        chk("R4 same-cycle write uses old value", longint'($signed(out_sample)), 1000);
        mc[0] = 16'sh2000;
        send(1000, 0, "R4 next sample uses new value", y, c);
        chk("R4 next sample explicit", longint'(y), 500);
    endtask

    task automatic t_round();
        int y; bit c;
        do_reset();
        wcoef(0, 16'h0001);
        send(8192, 0, "R7 half up", y, c);
        chk("R7 +0.5 rounds to 1", longint'(y), 1);
        send(8191, 0, "R7 below half", y, c);
        chk("R7 below half rounds to 0", longint'(y), 0);
        send(-8192, 0, "R7 negative half", y, c);
        chk("R7 -0.5 rounds to 0", longint'(y), 0);
        send(-8193, 0, "R7 below negative half", y, c);
        chk("R7 below -0.5 rounds to -1", longint'(y), -1);
    endtask

    task automatic t_sat();
        int y; bit c;
        do_reset();
        wcoef(0, 16'h7FFF);
        send(32767, 0, "R8 positive clamp", y, c);
        chk("R8 positive clamp code", longint'(y), 32767);
        chk("R8 positive clip flag", longint'(c), 1);
        send(-32768, 0, "R8 negative clamp", y, c);
        chk("R8 negative clamp code", longint'(y), -32768);
        do_reset();
        wcoef(0, 16'h4000);
        send(32767, 0, "R8 top in range", y, c);
        chk("R8 no clip at +max", longint'(c), 0);
        send(-32768, 0, "R8 bottom in range", y, c);
        chk("R8 no clip at -1.0", longint'(c), 0);
    endtask

    task automatic t_atten();
        int y; bit c;
        do_reset();
        wcoef(0, 16'h4000);
        send(16384, 1, "R9 shift by one", y, c);
        chk("R9 6 dB down", longint'(y), 8192);
        send(-5, 3, "R9 arithmetic shift", y, c);
        chk("R9 negative floor", longint'(y), -1);
        wcoef(0, 16'h0000);
        wcoef(1, 16'h4000);
        send(20000, 2, "R9 scaled value in history", y, c);
        send(0, 0, "R9 scaled value in history", y, c);
        chk("R9 history holds scaled input", longint'(y), 5000);
    endtask

    task automatic t_wrap();
        int y; bit c;
        do_reset();
        wcoef(0, 16'h7FFF);
        wcoef(1, 16'h7FFF);
        wcoef(2, 16'h7FFF);
        wcoef(3, 16'h7FFF);
        wcoef(4, 16'h7FFF);
        send(32767, 0, "R10 saturated feedback", y, c);
        send(32767, 0, "R10 saturated feedback", y, c);
        chk("R10 history saturated", longint'(y), 32767);
        send(50, 0, "R6 wrapped sum", y, c);
        chk("R6 wrap recovers in range", longint'(y), 100);
        chk("R6 no clip after wrap", longint'(c), 0);
    endtask

    initial begin
        t_reset();
        t_map();
        t_feedback();
        t_coef_timing();
        t_round();
        t_sat();
        t_atten();
        t_wrap();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule